// File: doc/BRIEF.md
# Self-Programming Command Window Controller

This block is the command and status logic that guards flash self-programming and boot-lock access in a small microcontroller. Software writes a five-bit command field whose bit 0 is the enable bit. A write that sets the enable bit opens a short countdown window. A store strobe or a load strobe from the CPU is honoured only while that window is open. If no strobe arrives in time, the command bits clear without any side effect.

A store strobe runs one of four commands. It can program boot lock bits, start a page erase, start a page write, or release the read-while-write (RWW) region. The page operations use a request/done handshake with an external flash model. They hold the RWW busy flag, which drives a read-block output, until software releases it. A load strobe in lock mode returns the boot lock byte. The lock readback window is one cycle shorter than the store window. While an EEPROM write is in progress, every command and every lock read is refused.

Top module: `spm_window_ctrl`

## Requirements
- R1: After a synchronous reset, `csr_rdata` is 0x00, `pg_req`, `rww_block` and `lock_rvalid` are low, and `boot_lock` is 4'hF (no lock bit is programmed).
- R2: A `csr_wr` with `csr_wdata[0]`=1 arms a command. The command field bits are: bit 0 enable, bit 1 page erase, bit 2 page write, bit 3 lock select, bit 4 RWW release. The armed bits read back in `csr_rdata[4:0]`, and `csr_rdata[6]` is the RWW busy flag. All other read bits are zero.
- R3: A store strobe is honoured on any of the four rising edges that follow the write edge. After the fourth edge with no honoured strobe, `csr_rdata[4:0]` returns to zero and later store strobes have no effect.
- R4: A store in lock mode programs `boot_lock[i]` (drives it to 0) for every `st_lock_data[i]` that is 0, and leaves the bit unchanged where the data bit is 1. A programmed bit returns to 1 only through reset.
- R5: A load strobe in lock mode on one of the first three edges after the write edge makes `lock_rvalid` high for one cycle after that edge. `lock_rdata` then equals {2'b11, boot_lock, 2'b11}, and the command bits clear.
- R6: A load strobe on the fourth edge after the write edge returns nothing, and the command bits clear at that edge.
- R7: While `ee_busy` is high, register writes do not arm a command and store or load strobes are ignored.
- R8: A store in erase or write mode raises `pg_req` and sets RWW busy. `pg_op` is 0 for erase and 1 for write. `pg_req` stays high until a `pg_done` pulse.
- R9: RWW busy, and so `rww_block`, stays set after `pg_done` until a store in RWW-release mode is honoured.
- R10: A store strobe sampled while `pg_req` is high is ignored, even on the edge where `pg_done` arrives. The armed window keeps running.
- R11: Lock programming does not change `rww_block`.
- R12: A write of the enable bit alone that is not followed by a strobe changes nothing except that the enable bit self-clears.
- R13: When several command bits are written together, the command is chosen in this order: RWW release, then lock, then page write, then page erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Command register write strobe |
| csr_wdata | input | 5 | Command field write data |
| csr_rdata | output | 8 | Command and status read value |
| spm_strobe | input | 1 | Store-program-memory strobe from the CPU |
| st_lock_data | input | 4 | Store operand lock field (operand bits 5..2) |
| lpm_strobe | input | 1 | Load-program-memory strobe from the CPU |
| ee_busy | input | 1 | EEPROM write in progress |
| pg_req | output | 1 | Page operation request to the flash model |
| pg_op | output | 1 | Page operation kind: 0 erase, 1 write |
| pg_done | input | 1 | Page operation completion pulse |
| rww_block | output | 1 | Read block for the RWW flash region |
| boot_lock | output | 4 | Current boot lock bits, 0 = programmed |
| lock_rdata | output | 8 | Lock readback byte |
| lock_rvalid | output | 1 | Lock readback valid pulse |

## Verification
The test makes two events land on the same edge: the completion pulse of a page operation and a store strobe for an RWW-release command that was armed while the page request was still outstanding. The bench drives both on one falling edge. At the next falling edge it expects the page request to have dropped, the busy flag to still be set, and the command to remain armed. A second strobe inside the same window must then clear the busy flag. The bench also places each strobe on the last edge that is accepted and on the first edge that is refused, for both window lengths.

// File: rtl/spm_win_pkg.sv
// Package: shared types and bit positions for the self-programming
// command window controller.
// Assumes: a five-bit command field; the enable bit sits at bit 0.
package spm_win_pkg;

    localparam int CMD_W     = 5;
    localparam int BIT_EN    = 0;
    localparam int BIT_ERASE = 1;
    localparam int BIT_WRITE = 2;
    localparam int BIT_LOCK  = 3;
    localparam int BIT_RWWRE = 4;
    localparam int BIT_BUSY  = 6;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_ERASE = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_LOCK  = 3'd3,
        CMD_RWWRE = 3'd4
    } spm_cmd_e;

endpackage

// File: rtl/spm_cmd_window.sv
// Module: spm_cmd_window
// Holds the armed command and its countdown window. Produces one-cycle
// go pulses when a store or load strobe is honoured.
// Assumes: strobes are synchronous single-cycle pulses. A register write
// in the same cycle as a strobe wins, and that strobe is dropped.
module spm_cmd_window
    import spm_win_pkg::*;
#(
    parameter int STORE_WIN = 4,
    parameter int LOAD_WIN  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CMD_W-1:0] csr_wdata,
    input  logic             ee_busy,
    input  logic             spm_strobe,
    input  logic             lpm_strobe,
    input  logic             pg_pending,
    output logic [CMD_W-1:0] cmd_bits,
    output spm_cmd_e         cmd_sel,
    output logic             store_go,
    output logic             load_go
);

    localparam int CNT_W = $clog2(STORE_WIN + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD  = CNT_W'(STORE_WIN);
    localparam logic [CNT_W-1:0] CNT_FLOOR = CNT_W'(STORE_WIN - LOAD_WIN);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    logic             armed_q;
    logic [CNT_W-1:0] win_cnt_q;
    logic [CMD_W-1:0] bits_q;
    spm_cmd_e         cmd_q;

    // Pick one command from the written field by fixed priority.
    function automatic spm_cmd_e decode_cmd(input logic [CMD_W-1:0] d);
        if (d[BIT_RWWRE])      return CMD_RWWRE;
        else if (d[BIT_LOCK])  return CMD_LOCK;
        else if (d[BIT_WRITE]) return CMD_WRITE;
        else if (d[BIT_ERASE]) return CMD_ERASE;
        else                   return CMD_NONE;
    endfunction

    logic accept_wr;
    logic base_ok;

    // Qualify strobes against window, EEPROM activity and page pending.
    always_comb begin
        accept_wr = csr_wr && !ee_busy;
        base_ok   = armed_q && !ee_busy && !csr_wr;
        store_go  = base_ok && spm_strobe && !pg_pending;
        load_go   = base_ok && lpm_strobe && (cmd_q == CMD_LOCK)
                    && (win_cnt_q > CNT_FLOOR);
    end

    // Arm on write, clear on honoured strobe or window expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            win_cnt_q <= '0;
            bits_q    <= '0;
            cmd_q     <= CMD_NONE;
        end else if (accept_wr) begin
            if (csr_wdata[BIT_EN]) begin
                armed_q   <= 1'b1;
                win_cnt_q <= CNT_LOAD;
                bits_q    <= csr_wdata;
                cmd_q     <= decode_cmd(csr_wdata);
            end else begin
                armed_q   <= 1'b0;
                win_cnt_q <= '0;
                bits_q    <= '0;
                cmd_q     <= CMD_NONE;
            end
        end else if (store_go || load_go) begin
            armed_q   <= 1'b0;
            win_cnt_q <= '0;
            bits_q    <= '0;
            cmd_q     <= CMD_NONE;
        end else if (win_cnt_q != '0) begin
            win_cnt_q <= win_cnt_q - CNT_ONE;
            if (win_cnt_q == CNT_ONE) begin
                armed_q <= 1'b0;
                bits_q  <= '0;
                cmd_q   <= CMD_NONE;
            end
        end
    end

    // Expose the armed view.
    always_comb begin
        cmd_bits = bits_q;
        cmd_sel  = cmd_q;
    end

    // R3: the armed flag and a running countdown always agree.
    assert_armed_tracks_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q == (win_cnt_q != '0));

    // R3: the countdown never exceeds the store window.
    assert_window_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt_q <= CNT_LOAD);

endmodule

// File: rtl/spm_lock_store.sv
// Module: spm_lock_store
// Holds the boot lock bits (1 = unprogrammed), programs them from a store
// operand and returns a padded readback byte.
// Assumes: go pulses come from the command window and are single-cycle.
module spm_lock_store #(
    parameter int LOCK_W   = 4,
    parameter int LOCK_LSB = 2,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic [LOCK_W-1:0] prog_data,
    input  logic              read_go,
    output logic [LOCK_W-1:0] lock_bits,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [LOCK_W-1:0] lock_q;
    logic [DATA_W-1:0] rd_q;
    logic              rv_q;
    logic [DATA_W-1:0] packed_lock;

    // One flop per lock bit: a zero operand bit programs it, never undone.
    for (genvar i = 0; i < LOCK_W; i++) begin : g_lock
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[i] <= 1'b1;
            else if (prog_go && !prog_data[i])
                lock_q[i] <= 1'b0;
        end
    end

    // Build the readback byte: padding bits read as one.
    always_comb begin
        packed_lock = '1;
        packed_lock[LOCK_LSB +: LOCK_W] = lock_q;
    end

    // Register the readback and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            rv_q <= 1'b0;
        end else begin
            rv_q <= read_go;
            if (read_go)
                rd_q <= packed_lock;
        end
    end

    assign lock_bits = lock_q;
    assign rdata     = rd_q;
    assign rvalid    = rv_q;

    // R4: a programmed lock bit never returns to one outside reset.
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(lock_q)) & lock_q) == '0);

    // R5: readback valid is a single-cycle pulse.
    assert_rvalid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rv_q |=> !rv_q);

endmodule

// File: rtl/spm_rww_tracker.sv
// Module: spm_rww_tracker
// Runs the page request handshake and the sticky read-while-write busy flag.
// Assumes: pg_done is a pulse; a pulse with no request outstanding is ignored.
module spm_rww_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic page_go,
    input  logic page_is_write,
    input  logic rwwre_go,
    input  logic pg_done,
    output logic pg_req,
    output logic pg_op,
    output logic rww_busy
);

    logic req_q;
    logic op_q;
    logic busy_q;

    // Request handshake: raise on page go, drop on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            op_q  <= 1'b0;
        end else if (page_go) begin
            req_q <= 1'b1;
            op_q  <= page_is_write;
        end else if (req_q && pg_done) begin
            req_q <= 1'b0;
        end
    end

    // Busy flag: set by a page go, cleared only by a release command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (page_go)
            busy_q <= 1'b1;
        else if (rwwre_go)
            busy_q <= 1'b0;
    end

    assign pg_req   = req_q;
    assign pg_op    = op_q;
    assign rww_busy = busy_q;

    // R8: an outstanding page request always keeps the region busy.
    assert_req_implies_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> busy_q);

    // R9: busy falls only after a release command.
    assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(rwwre_go));

    // R10: no new page operation starts while one is outstanding.
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !pg_done) |=> $stable(op_q) && req_q);

endmodule

// File: rtl/spm_window_ctrl.sv
// Module: spm_window_ctrl (top)
// Self-programming command window controller. It ties together the armed
// command window, the boot lock store and the RWW busy tracker, and
// presents the status register view.
// Assumes: the flash array, EEPROM and CPU sit outside and use the
// strobe and handshake ports.
module spm_window_ctrl
    import spm_win_pkg::*;
#(
    parameter int STORE_WIN = 4,
    parameter int LOAD_WIN  = 3,
    parameter int LOCK_W    = 4,
    parameter int LOCK_LSB  = 2,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [CMD_W-1:0]  csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic              spm_strobe,
    input  logic [LOCK_W-1:0] st_lock_data,
    input  logic              lpm_strobe,
    input  logic              ee_busy,
    output logic              pg_req,
    output logic              pg_op,
    input  logic              pg_done,
    output logic              rww_block,
    output logic [LOCK_W-1:0] boot_lock,
    output logic [DATA_W-1:0] lock_rdata,
    output logic              lock_rvalid
);

    logic [CMD_W-1:0] cmd_bits;
    spm_cmd_e         cmd_sel;
    logic             store_go;
    logic             load_go;
    logic             lock_prog_go;
    logic             page_go;
    logic             page_is_write;
    logic             rwwre_go;
    logic             rww_busy;

    spm_cmd_window #(
        .STORE_WIN (STORE_WIN),
        .LOAD_WIN  (LOAD_WIN)
    ) win_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_wr     (csr_wr),
        .csr_wdata  (csr_wdata),
        .ee_busy    (ee_busy),
        .spm_strobe (spm_strobe),
        .lpm_strobe (lpm_strobe),
        .pg_pending (pg_req),
        .cmd_bits   (cmd_bits),
        .cmd_sel    (cmd_sel),
        .store_go   (store_go),
        .load_go    (load_go)
    );

    // Route an honoured store to the unit named by the armed command.
    always_comb begin
        lock_prog_go  = store_go && (cmd_sel == CMD_LOCK);
        page_go       = store_go && ((cmd_sel == CMD_ERASE) || (cmd_sel == CMD_WRITE));
        page_is_write = (cmd_sel == CMD_WRITE);
        rwwre_go      = store_go && (cmd_sel == CMD_RWWRE);
    end

    spm_lock_store #(
        .LOCK_W   (LOCK_W),
        .LOCK_LSB (LOCK_LSB),
        .DATA_W   (DATA_W)
    ) lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_go   (lock_prog_go),
        .prog_data (st_lock_data),
        .read_go   (load_go),
        .lock_bits (boot_lock),
        .rdata     (lock_rdata),
        .rvalid    (lock_rvalid)
    );

    spm_rww_tracker rww_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .page_go       (page_go),
        .page_is_write (page_is_write),
        .rwwre_go      (rwwre_go),
        .pg_done       (pg_done),
        .pg_req        (pg_req),
        .pg_op         (pg_op),
        .rww_busy      (rww_busy)
    );

    // Status view: armed bits low, busy flag at its fixed position.
    always_comb begin
        csr_rdata = '0;
        csr_rdata[CMD_W-1:0] = cmd_bits;
        csr_rdata[BIT_BUSY]  = rww_busy;
        rww_block = rww_busy;
    end

    // R11: lock programming leaves the read block untouched.
    assert_lock_keeps_rww_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_prog_go |=> $stable(rww_block));

    // R7: no lock readback follows a cycle with EEPROM activity.
    assert_ee_blocks_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_rvalid |-> $past(!ee_busy));

endmodule

// File: tb/spm_window_ctrl_tb.sv
`timescale 1ns/1ps
module spm_window_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       csr_wr;
    logic [4:0] csr_wdata;
    logic [7:0] csr_rdata;
    logic       spm_strobe;
    logic [3:0] st_lock_data;
    logic       lpm_strobe;
    logic       ee_busy;
    logic       pg_req;
    logic       pg_op;
    logic       pg_done;
    logic       rww_block;
    logic [3:0] boot_lock;
    logic [7:0] lock_rdata;
    logic       lock_rvalid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    spm_window_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .csr_wr       (csr_wr),
        .csr_wdata    (csr_wdata),
        .csr_rdata    (csr_rdata),
        .spm_strobe   (spm_strobe),
        .st_lock_data (st_lock_data),
        .lpm_strobe   (lpm_strobe),
        .ee_busy      (ee_busy),
        .pg_req       (pg_req),
        .pg_op        (pg_op),
        .pg_done      (pg_done),
        .rww_block    (rww_block),
        .boot_lock    (boot_lock),
        .lock_rdata   (lock_rdata),
        .lock_rvalid  (lock_rvalid)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_csr(input logic [4:0] d);
        csr_wr = 1'b1;
        csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic do_store(input logic [3:0] d);
        spm_strobe = 1'b1;
        st_lock_data = d;
        @(negedge clk);
        spm_strobe = 1'b0;
    endtask

    task automatic do_load();
        lpm_strobe = 1'b1;
        @(negedge clk);
        lpm_strobe = 1'b0;
    endtask

    // Monitor: every readback pulse is matched against the expected queue.
    always @(negedge clk) begin
        if (rst_n && lock_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R6: unexpected readback actual 0x%02h expected none", lock_rdata);
            end else begin
                chk("R5 readback", lock_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; csr_wr = 1'b0; csr_wdata = '0; spm_strobe = 1'b0;
        st_lock_data = '0; lpm_strobe = 1'b0; ee_busy = 1'b0; pg_done = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 csr", csr_rdata, 8'h00);
        chk("R1 req/block/rv", {5'b0, pg_req, rww_block, lock_rvalid}, 8'h00);
        chk("R1 lock", {4'h0, boot_lock}, 8'h0F);

        // R5 readback of unprogrammed locks, immediate strobe
        exp_q.push_back(8'hFF);
        write_csr(5'h09);
        do_load();
        chk("R5 cmd cleared", csr_rdata, 8'h00);

        // R2 arm and read back; R4 program bit 1; R11 no busy
        write_csr(5'h09);
        chk("R2 armed bits", csr_rdata, 8'h09);
        do_store(4'hD);
        chk("R4 program bit1", {4'h0, boot_lock}, 8'h0D);
        chk("R11 rww unchanged", {7'h0, rww_block}, 8'h00);
        chk("R3 cleared after store", csr_rdata, 8'h00);

        // R3 last accepted store slot (fourth edge)
        write_csr(5'h09);
        idle(3);
        do_store(4'h7);
        chk("R3 last slot", {4'h0, boot_lock}, 8'h05);

        // R3 one edge late
        write_csr(5'h09);
        idle(4);
        chk("R3 expiry clears", csr_rdata, 8'h00);
        do_store(4'hE);
        chk("R3 late store ignored", {4'h0, boot_lock}, 8'h05);

        // R4 ones cannot unprogram
        write_csr(5'h09);
        do_store(4'hF);
        chk("R4 sticky", {4'h0, boot_lock}, 8'h05);

        // R5 load on the third edge accepted
        exp_q.push_back(8'hD7);
        write_csr(5'h09);
        idle(2);
        do_load();

        // R6 load on the fourth edge refused
        write_csr(5'h09);
        idle(3);
        do_load();
        chk("R6 no readback", {7'h0, lock_rvalid}, 8'h00);
        chk("R6 cmd cleared", csr_rdata, 8'h00);

        // R7 EEPROM activity blocks arming and strobes
        ee_busy = 1'b1;
        write_csr(5'h09);
        chk("R7 write refused", csr_rdata, 8'h00);
        ee_busy = 1'b0;
        write_csr(5'h09);
        ee_busy = 1'b1;
        do_store(4'h0);
        chk("R7 store refused", {4'h0, boot_lock}, 8'h05);
        do_load();
        chk("R7 load refused", {7'h0, lock_rvalid}, 8'h00);
        ee_busy = 1'b0;
        idle(4);

        // R13 lock wins over page commands
        write_csr(5'h0F);
        do_store(4'hB);
        chk("R13 lock chosen", {4'h0, boot_lock}, 8'h01);
        chk("R13 no page req", {7'h0, pg_req}, 8'h00);

        // R12 enable alone expires quietly
        write_csr(5'h01);
        idle(5);
        chk("R12 csr", csr_rdata, 8'h00);
        chk("R12 no effect", {4'h0, pg_req, rww_block, boot_lock[1:0]}, 8'h01);

        // R8 page erase
        write_csr(5'h03);
        do_store(4'h0);
        chk("R8 erase req", {6'h0, pg_req, pg_op}, 8'h02);
        chk("R8 busy status", csr_rdata, 8'h40);

        // R10 store while pending is ignored
        write_csr(5'h05);
        do_store(4'h0);
        chk("R10 op unchanged", {6'h0, pg_req, pg_op}, 8'h02);

        // R10 release store on the same edge as done
        write_csr(5'h11);
        spm_strobe = 1'b1;
        pg_done = 1'b1;
        @(negedge clk);
        spm_strobe = 1'b0;
        pg_done = 1'b0;
        chk("R10 req dropped", {7'h0, pg_req}, 8'h00);
        chk("R9 busy held after done", {7'h0, rww_block}, 8'h01);
        chk("R10 still armed", csr_rdata, 8'h51);
        do_store(4'h0);
        chk("R9 released", {7'h0, rww_block}, 8'h00);
        chk("R9 csr", csr_rdata, 8'h00);

        // R8 page write held until done
        write_csr(5'h05);
        do_store(4'h0);
        chk("R8 write req", {6'h0, pg_req, pg_op}, 8'h03);
        idle(6);
        chk("R8 waits for done", {7'h0, pg_req}, 8'h01);
        pg_done = 1'b1;
        @(negedge clk);
        pg_done = 1'b0;
        chk("R8 done drops req", {7'h0, pg_req}, 8'h00);
        chk("R9 busy sticky", {7'h0, rww_block}, 8'h01);
        write_csr(5'h11);
        do_store(4'h0);
        chk("R9 release", {7'h0, rww_block}, 8'h00);

        idle(2);
        chk("R5 all readbacks seen", 8'(exp_q.size()), 8'h00);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule